// File: doc/BRIEF.md
# Packed Byte Pointer Load/Deposit Unit

This block moves variable-width bit fields in and out of 36-bit memory words. A request carries a pointer made of an 18-bit word address, a 6-bit position (the number of word bits lying to the right of the field) and a 6-bit size. A load fetches the word and returns the field right-aligned and zero-filled. A deposit reads the word, replaces the field with the low bits of an accumulator value, and writes the word back. Every other bit of the word is kept. A field may be any width from 1 to 36 bits and always lies inside one word. Memory is only ever touched as a whole word, through a single synchronous port that returns read data one cycle after the request.

Three further operations walk the pointer through packed data. A step lowers the position by the size. When too few bits remain for another field, the step moves to the next word and leaves the low spare bits unused. Step-then-load and step-then-deposit perform the step first and then access the field at the new pointer. Extraction uses a mask and barrel shift, so the number of cycles depends only on the operation and never on the position.

A controller drives the block with a valid/ready handshake. A one-cycle done pulse returns the updated pointer and, for loads, the field. The state machine has five states. IDLE accepts a request and goes to FETCH for load or deposit kinds, or to RESP for the others. FETCH issues the read and goes to WAIT. WAIT captures the field or the merged word and goes to RESP for loads or to STORE for deposits. STORE writes the word and goes to RESP. RESP pulses done and returns to IDLE.

Top module: `bp_unit`

## Requirements
- R1: After reset, req_ready is 1, done is 0 and mem_en is 0.
- R2: Op code 0 (load) returns in done_data the word bits [pos+size-1:pos], placed at bit 0 with all higher bits zero. done rises in the third cycle after acceptance, whatever the position.
- R3: Op code 1 (deposit) reads the word and writes it back to the same address. The field bits take acc[size-1:0] and all other bits keep their old value. done rises in the fourth cycle after acceptance, done_data is 0, and exactly two memory cycles are used.
- R4: Op code 2 (step), when pos >= size, returns pos-size with the address unchanged. Otherwise it returns address+1 with pos = 36-size, or pos = 0 when size >= 36. done rises in the first cycle after acceptance and memory is not enabled.
- R5: Op code 3 (step-then-load) and op code 4 (step-then-deposit) apply the R4 step first. They then behave as R2 and R3 at the new pointer, and done returns the new pointer.
- R6: A size of 0 makes a load return 0 and leaves the word unchanged on a deposit.
- R7: A field that extends past bit 35 is clipped to the bits inside the word. A position of 36 or more selects no bits.
- R8: req_ready is 1 only in IDLE, and a request is taken when req_valid and req_ready are both 1. done is a single-cycle pulse. Op codes 5, 6 and 7 finish one cycle after acceptance with no memory access, the pointer unchanged and done_data 0.
- R9: Repeated step-then-load with size 7 from position 36 visits positions 29, 22, 15, 8 and 1. The next step moves to address+1 at position 29, leaving bit 0 of each word unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_op | input | 3 | Operation code |
| req_pos | input | 6 | Pointer position (bits to the right of the field) |
| req_size | input | 6 | Pointer field size in bits |
| req_addr | input | 18 | Pointer word address |
| req_acc | input | 36 | Accumulator value for deposits |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 18 | Memory word address |
| mem_wdata | output | 36 | Memory write data |
| mem_rdata | input | 36 | Memory read data, valid the cycle after a read |
| done | output | 1 | Operation complete pulse |
| done_pos | output | 6 | Updated pointer position |
| done_size | output | 6 | Pointer size |
| done_addr | output | 18 | Updated pointer address |
| done_data | output | 36 | Loaded field, zero for other operations |

## Verification
A state register stuck or mis-sequenced shows up at once as a done pulse that comes a cycle early or late for its operation. It can also show as a missing or extra memory enable, which the bench counts for every transaction. A wrong mask or shift amount corrupts the loaded field, or the neighbouring bits of the written word, in the very transaction that uses it. The bench checks the word in its own memory immediately after each deposit. A wrong step borrow shows in done_pos and done_addr on the step's own done pulse, and it shifts every later access in the packed walk.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [2:0] {
        OP_LOAD         = 3'd0,
        OP_DEPOSIT      = 3'd1,
        OP_STEP         = 3'd2,
        OP_STEP_LOAD    = 3'd3,
        OP_STEP_DEPOSIT = 3'd4
    } bp_op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_WAIT  = 3'd2,
        ST_STORE = 3'd3,
        ST_RESP  = 3'd4
    } bp_state_e;

endpackage

// File: rtl/bp_step.sv
module bp_step #(
    parameter int WORD_W = 36,
    parameter int ADDR_W = 18,
    parameter int FLD_W  = 6
) (
    input  logic [FLD_W-1:0]  pos,
    input  logic [FLD_W-1:0]  size,
    input  logic [ADDR_W-1:0] addr,
    output logic [FLD_W-1:0]  next_pos,
    output logic [ADDR_W-1:0] next_addr
);
    localparam logic [FLD_W-1:0] WLIM = FLD_W'(WORD_W);

    logic [FLD_W:0] diff;
    logic           borrow;

    always_comb begin
        diff   = {1'b0, pos} - {1'b0, size};
        borrow = diff[FLD_W];
        if (!borrow) begin
            next_pos  = diff[FLD_W-1:0];
            next_addr = addr;
        end else begin
            next_addr = addr + ADDR_W'(1);
            next_pos  = (size >= WLIM) ? '0 : (WLIM - size);
        end
    end
endmodule

// File: rtl/bp_field.sv
module bp_field #(
    parameter int WORD_W = 36,
    parameter int FLD_W  = 6
) (
    input  logic [WORD_W-1:0] word,
    input  logic [FLD_W-1:0]  pos,
    input  logic [FLD_W-1:0]  size,
    input  logic [WORD_W-1:0] acc,
    output logic [WORD_W-1:0] field,
    output logic [WORD_W-1:0] merged
);
    localparam logic [FLD_W-1:0] WLIM = FLD_W'(WORD_W);

    logic [WORD_W-1:0] ones;
    logic [WORD_W-1:0] mask;

    always_comb begin
        if (size >= WLIM) ones = '1;
        else              ones = (WORD_W'(1) << size) - WORD_W'(1);
        if (pos >= WLIM)  mask = '0;
        else              mask = ones << pos;
        field  = (word & mask) >> pos;
        merged = (word & ~mask) | ((acc << pos) & mask);
    end
endmodule

// File: rtl/bp_unit.sv
module bp_unit
    import bp_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int ADDR_W = 18,
    parameter int FLD_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [FLD_W-1:0]  req_pos,
    input  logic [FLD_W-1:0]  req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_acc,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              done,
    output logic [FLD_W-1:0]  done_pos,
    output logic [FLD_W-1:0]  done_size,
    output logic [ADDR_W-1:0] done_addr,
    output logic [WORD_W-1:0] done_data
);
    bp_state_e state, state_nx;

    logic              accept;
    logic              dec_step, dec_load, dec_dep;
    logic [FLD_W-1:0]  step_pos;
    logic [ADDR_W-1:0] step_addr;
    logic              is_load_q, is_dep_q;
    logic [FLD_W-1:0]  pos_q, size_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] acc_q, data_q;
    logic [WORD_W-1:0] fld_out, mrg_out;

    assign accept = req_valid && (state == ST_IDLE);

    always_comb begin
        dec_step = 1'b0;
        dec_load = 1'b0;
        dec_dep  = 1'b0;
        case (req_op)
            OP_LOAD:         dec_load = 1'b1;
            OP_DEPOSIT:      dec_dep  = 1'b1;
            OP_STEP:         dec_step = 1'b1;
            OP_STEP_LOAD:    begin dec_step = 1'b1; dec_load = 1'b1; end
            OP_STEP_DEPOSIT: begin dec_step = 1'b1; dec_dep  = 1'b1; end
            default:         ;
        endcase
    end

    bp_step #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .FLD_W(FLD_W)) u_step (
        .pos       (req_pos),
        .size      (req_size),
        .addr      (req_addr),
        .next_pos  (step_pos),
        .next_addr (step_addr)
    );

    bp_field #(.WORD_W(WORD_W), .FLD_W(FLD_W)) u_field (
        .word   (mem_rdata),
        .pos    (pos_q),
        .size   (size_q),
        .acc    (acc_q),
        .field  (fld_out),
        .merged (mrg_out)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = (dec_load || dec_dep) ? ST_FETCH : ST_RESP;
            ST_FETCH: state_nx = ST_WAIT;
            ST_WAIT:  state_nx = is_dep_q ? ST_STORE : ST_RESP;
            ST_STORE: state_nx = ST_RESP;
            ST_RESP:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_load_q <= 1'b0;
            is_dep_q  <= 1'b0;
            pos_q     <= '0;
            size_q    <= '0;
            addr_q    <= '0;
            acc_q     <= '0;
            data_q    <= '0;
        end else begin
            if (accept) begin
                is_load_q <= dec_load;
                is_dep_q  <= dec_dep;
                pos_q     <= dec_step ? step_pos  : req_pos;
                addr_q    <= dec_step ? step_addr : req_addr;
                size_q    <= req_size;
                acc_q     <= req_acc;
                data_q    <= '0;
            end else if (state == ST_WAIT) begin
                data_q <= is_dep_q ? mrg_out : fld_out;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        mem_en    = (state == ST_FETCH) || (state == ST_STORE);
        mem_we    = (state == ST_STORE);
        mem_addr  = addr_q;
        mem_wdata = data_q;
        done      = (state == ST_RESP);
        done_pos  = pos_q;
        done_size = size_q;
        done_addr = addr_q;
        done_data = (done && is_load_q) ? data_q : '0;
    end
endmodule

// File: rtl/bp_unit_chk.sv
module bp_unit_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        req_op,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done
);
    // R8
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3
    we_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_en);
    // R3
    wr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == $past(mem_addr, 2)));
    // R4
    step_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 3'd2) |=> (done && !mem_en));
    // R2
    load_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 3'd0) |-> ##3 done);
endmodule

bind bp_unit bp_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .done      (done)
);

// File: tb/bp_unit_tb.sv
`timescale 1ns/1ps
module bp_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic [5:0]  req_pos = '0, req_size = '0;
    logic [17:0] req_addr = '0;
    logic [35:0] req_acc = '0;
    logic        mem_en, mem_we;
    logic [17:0] mem_addr;
    logic [35:0] mem_wdata;
    logic [35:0] mem_rdata = '0;
    logic        done;
    logic [5:0]  done_pos, done_size;
    logic [17:0] done_addr;
    logic [35:0] done_data;

    int checks = 0;
    int errors = 0;
    int memcnt = 0;

    logic [35:0] mem [16];
    logic [35:0] mdl [16];

    always #2.5 clk = ~clk;

    bp_unit u_dut (.*);

    always @(posedge clk) begin
        if (mem_en) begin
            memcnt <= memcnt + 1;
            if (mem_we) mem[mem_addr[3:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[3:0]];
        end
    end

    typedef struct packed {
        logic [2:0]  op;
        logic [5:0]  pos;
        logic [5:0]  size;
        logic [17:0] addr;
        logic [35:0] acc;
        logic [5:0]  epos;
        logic [17:0] eaddr;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{3'd0,  6'd0, 6'd36, 18'd1, 36'h0,          6'd0,  18'd1, 4'd0},
        '{3'd0,  6'd6, 6'd8,  18'd2, 36'h0,          6'd6,  18'd2, 4'd0},
        '{3'd0,  6'd30,6'd10, 18'd3, 36'h0,          6'd30, 18'd3, 4'd7},
        '{3'd1,  6'd4, 6'd12, 18'd4, 36'hABCDEF123,  6'd4,  18'd4, 4'd0},
        '{3'd0,  6'd4, 6'd12, 18'd4, 36'h0,          6'd4,  18'd4, 4'd0},
        '{3'd2,  6'd20,6'd7,  18'd5, 36'h0,          6'd13, 18'd5, 4'd0},
        '{3'd2,  6'd3, 6'd7,  18'd5, 36'h0,          6'd29, 18'd6, 4'd0},
        '{3'd3,  6'd1, 6'd7,  18'd6, 36'h0,          6'd29, 18'd7, 4'd0},
        '{3'd4,  6'd8, 6'd8,  18'd7, 36'h5A5A5A5A5,  6'd0,  18'd7, 4'd0},
        '{3'd4,  6'd5, 6'd9,  18'd8, 36'hFFFFFFFFF,  6'd27, 18'd9, 4'd0},
        '{3'd0,  6'd0, 6'd0,  18'd9, 36'h0,          6'd0,  18'd9, 4'd6},
        '{3'd1,  6'd10,6'd0,  18'd9, 36'hFFFFFFFFF,  6'd10, 18'd9, 4'd6},
        '{3'd2,  6'd10,6'd40, 18'd2, 36'h0,          6'd0,  18'd3, 4'd0},
        '{3'd5,  6'd7, 6'd3,  18'd11,36'h0,          6'd7,  18'd11,4'd0},
        '{3'd0,  6'd40,6'd5,  18'd10,36'h0,          6'd40, 18'd10,4'd7}
    };

    function automatic logic [35:0] ref_get(input logic [35:0] w, input int p, input int s);
        logic [35:0] r = '0;
        for (int i = 0; i < 36; i++) if (i >= p && i < p + s) r[i-p] = w[i];
        return r;
    endfunction

    function automatic logic [35:0] ref_put(input logic [35:0] w, input logic [35:0] a,
                                             input int p, input int s);
        logic [35:0] r = w;
        for (int i = 0; i < 36; i++) if (i >= p && i < p + s) r[i] = a[i-p];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] op, input logic [3:0] t);
        if (t == 4'd6) return "R6";
        if (t == 4'd7) return "R7";
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3, 3'd4: return "R5";
            default: return "R8";
        endcase
    endfunction

    // issue one request and check everything about it
    task automatic run(input logic [2:0] op, input logic [5:0] p, input logic [5:0] s,
                       input logic [17:0] a, input logic [35:0] acc,
                       input logic [5:0] ep, input logic [17:0] ea, input string tg);
        int lat, explat, expmem, m0;
        logic [35:0] expdata;
        bit isld, isdp;
        isld = (op == 3'd0) || (op == 3'd3);
        isdp = (op == 3'd1) || (op == 3'd4);
        explat = isdp ? 4 : (isld ? 3 : 1);
        expmem = isdp ? 2 : (isld ? 1 : 0);
        expdata = isld ? ref_get(mdl[ea[3:0]], int'(ep), int'(s)) : 36'h0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_pos = p; req_size = s;
        req_addr = a; req_acc = acc;
        m0 = memcnt;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        if (explat > 1) chk(req_ready == 1'b0, "R8", "ready while busy", 64'(req_ready), 64'd0);
        while (!done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == explat, tg, "latency", 64'(lat), 64'(explat));
        chk(done_pos == ep, tg, "pos", 64'(done_pos), 64'(ep));
        chk(done_addr == ea, tg, "addr", 64'(done_addr), 64'(ea));
        chk(done_data == expdata, tg, "data", 64'(done_data), 64'(expdata));
        chk(memcnt - m0 == expmem, tg, "mem cycles", 64'(memcnt - m0), 64'(expmem));
        if (isdp) begin
            mdl[ea[3:0]] = ref_put(mdl[ea[3:0]], acc, int'(ep), int'(s));
            chk(mem[ea[3:0]] == mdl[ea[3:0]], tg, "stored word",
                64'(mem[ea[3:0]]), 64'(mdl[ea[3:0]]));
        end
        @(negedge clk);
        chk(done == 1'b0, "R8", "done pulse width", 64'(done), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i] = 36'h9A5C3E71B ^ (36'(i) * 36'h111111111);
            mdl[i] = mem[i];
        end
        repeat (4) @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready in reset", 64'(req_ready), 64'd1);
        chk(done == 1'b0, "R1", "done in reset", 64'(done), 64'd0);
        chk(mem_en == 1'b0, "R1", "mem_en in reset", 64'(mem_en), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && !done && !mem_en, "R1", "idle after reset",
            64'({req_ready, done, mem_en}), 64'b100);

        for (int v = 0; v < NV; v++)
            run(VEC[v].op, VEC[v].pos, VEC[v].size, VEC[v].addr, VEC[v].acc,
                VEC[v].epos, VEC[v].eaddr, tag_of(VEC[v].op, VEC[v].tag));

        // R9: packed 7-bit walk, bit 0 left unused
        begin
            logic [5:0]  p;
            logic [17:0] a;
            p = 6'd36; a = 18'd12;
            for (int k = 0; k < 6; k++) begin
                logic [5:0]  np;
                logic [17:0] na;
                if (k < 5) begin np = 6'(29 - 7 * k); na = 18'd12; end
                else       begin np = 6'd29;          na = 18'd13; end
                run(3'd3, p, 6'd7, a, 36'h0, np, na, "R9");
                p = np; a = na;
            end
        end

        // R6: full-word read shows size-0 deposit left word 9 intact
        run(3'd0, 6'd0, 6'd36, 18'd9, 36'h0, 6'd0, 18'd9, "R6");
        // R7: deposit clipped at bit 35 keeps low bits
        run(3'd1, 6'd32, 6'd10, 18'd14, 36'hFFFFFFFFF, 6'd32, 18'd14, "R7");
        // R4: step with size exactly 36 from position 35
        run(3'd2, 6'd35, 6'd36, 18'd20, 36'h0, 6'd0, 18'd21, "R4");
        // R8: reserved code 7
        run(3'd7, 6'd12, 6'd5, 18'd3, 36'h0, 6'd12, 18'd3, "R8");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule